// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core. Nine sources feed it: three core sources (external edge pin, port-change on the upper port pins, timer-0 overflow) and six peripheral sources (converter done, timer-1 overflow, timer-2 period match, capture/compare, synchronous serial port, display module). Each source has a sticky flag and an enable bit. Every peripheral term also passes through a group enable, and all terms pass through a global enable.

Software reads and writes three registers through a simple port. When the core sees `irq_req_o`, it accepts the interrupt by raising `irq_ack_i`. In that cycle the block pulses `push_ret_o` so the core pushes its return address. The block also drops the global enable, and the core fetches from the fixed `vector_o`. A return strobe from the core sets the global enable again.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, every register reads 0x00, `irq_req_o` and `push_ret_o` are 0, and `vector_o` is 0x0004.
- R2: A pulse on a bit of `core_evt_i` or `periph_evt_i` sets the matching flag at the next edge, whatever the state of its own enable, the group enable or the global enable.
- R3: Address 0 is the main control register: bit 7 global enable, bit 6 peripheral group enable, bits 5/4/3 enables and bits 2/1/0 flags for external pin / timer-0 / port-change. `core_evt_i[k]` sets main bit k. Address 1 holds the peripheral flags and address 2 the peripheral enables, with bit k tied to `periph_evt_i[k]`. Address 3 reads 0.
- R4: A core source raises `irq_req_o` only when its flag and its own enable (main bit k+3) are both set.
- R5: A peripheral source raises `irq_req_o` only when its flag, its enable and the group enable are all set.
- R6: While the global enable is 0, `irq_req_o` stays 0, whatever flags are pending.
- R7: When `irq_ack_i` is high while `irq_req_o` is high, `push_ret_o` is high in that cycle and the global enable is 0 from the next edge. This clear takes priority over a return strobe and over a software write.
- R8: A pulse on `ret_i`, with no interrupt being taken, sets the global enable at the next edge. It takes priority over a software write.
- R9: Flags clear only through software writes. A flag still set when `ret_i` arrives raises `irq_req_o` again.
- R10: If an event and a software write to the same flag fall in the same cycle, the flag ends set.
- R11: With all enables set, `irq_req_o` rises at the first clock edge after the event cycle.
- R12: `irq_ack_i` while `irq_req_o` is low has no effect: `push_ret_o` stays 0 and the global enable is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| core_evt_i | input | 3 | Core source event pulses (port-change, timer-0, external) |
| periph_evt_i | input | 6 | Peripheral event pulses |
| irq_ack_i | input | 1 | Core takes the interrupt |
| ret_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | Interrupt request to the core |
| push_ret_o | output | 1 | Push return address, valid in the accept cycle |
| vector_o | output | 13 | Fixed vector address |

## Verification
The case hardest to reach is a collision in one cycle. A write that clears flags meets an event on one of those flags, or an accept meets a return strobe. The bench reaches these by driving the write strobe and the event pulse, or the acknowledge and the return strobe, from the same negative edge. It then reads the register back, or checks the request, after the following edge. The re-trigger after return is reached by taking an interrupt with its flag left set and then strobing `ret_i`.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DW          = 8;
  localparam int N_CORE      = 3;
  localparam int CORE_EN_LSB = 3;
  localparam int MAIN_GRP    = 6;
  localparam int MAIN_GLB    = 7;

  typedef enum logic [1:0] {
    ADDR_MAIN  = 2'd0,
    ADDR_PFLAG = 2'd1,
    ADDR_PEN   = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_main_reg.sv
module irq_main_reg
  import irq_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N_CORE-1:0] evt_i,
  input  logic              take_i,
  input  logic              ret_i,
  output logic [DW-1:0]     q_o
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = q_o;
    if (wr_i) nxt = wdata_i;
    nxt[N_CORE-1:0] = nxt[N_CORE-1:0] | evt_i;  // hardware set beats write
    if (take_i)     nxt[MAIN_GLB] = 1'b0;
    else if (ret_i) nxt[MAIN_GLB] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end

  assert_take_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !q_o[MAIN_GLB]);
  assert_ret_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !take_i) |=> q_o[MAIN_GLB]);

  for (genvar k = 0; k < N_CORE; k++) begin : g_chk
    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> q_o[k]);
    assert_flag_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[k] && !wr_i) |=> q_o[k]);
  end
endmodule

// File: rtl/irq_periph_reg.sv
module irq_periph_reg #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_flag_i,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o
);
  for (genvar k = 0; k < N; k++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[k] <= 1'b0;
        en_o[k]   <= 1'b0;
      end else begin
        flag_o[k] <= (wr_flag_i ? wdata_i[k] : flag_o[k]) | evt_i[k];
        if (wr_en_i) en_o[k] <= wdata_i[k];
      end
    end

    assert_evt_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> flag_o[k]);
    assert_flag_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[k] && !wr_flag_i) |=> flag_o[k]);
  end
endmodule

// File: rtl/irq_req_logic.sv
module irq_req_logic #(
  parameter int NC = 3,
  parameter int NP = 6
) (
  input  logic          glb_en_i,
  input  logic          grp_en_i,
  input  logic [NC-1:0] core_flag_i,
  input  logic [NC-1:0] core_en_i,
  input  logic [NP-1:0] per_flag_i,
  input  logic [NP-1:0] per_en_i,
  output logic          req_o
);
  logic core_hit, per_hit;

  always_comb begin
    core_hit = |(core_flag_i & core_en_i);
    per_hit  = grp_en_i & |(per_flag_i & per_en_i);
    req_o    = glb_en_i & (core_hit | per_hit);
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int              N_PERIPH = 6,
  parameter int              VEC_W    = 13,
  parameter logic [VEC_W-1:0] VECTOR  = 13'h0004
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  input  logic [N_CORE-1:0]   core_evt_i,
  input  logic [N_PERIPH-1:0] periph_evt_i,
  input  logic                irq_ack_i,
  input  logic                ret_i,
  output logic                irq_req_o,
  output logic                push_ret_o,
  output logic [VEC_W-1:0]    vector_o
);
  logic [DW-1:0]       main_q;
  logic [N_PERIPH-1:0] pflag, pen;
  logic                take;
  logic                wr_main, wr_pflag, wr_pen;

  assign wr_main  = reg_wr_i && (reg_addr_i == ADDR_MAIN);
  assign wr_pflag = reg_wr_i && (reg_addr_i == ADDR_PFLAG);
  assign wr_pen   = reg_wr_i && (reg_addr_i == ADDR_PEN);
  assign take       = irq_ack_i & irq_req_o;
  assign push_ret_o = take;
  assign vector_o   = VECTOR;

  irq_main_reg u_main (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_main),
    .wdata_i (reg_wdata_i),
    .evt_i   (core_evt_i),
    .take_i  (take),
    .ret_i   (ret_i),
    .q_o     (main_q)
  );

  irq_periph_reg #(.N(N_PERIPH)) u_periph (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_flag_i (wr_pflag),
    .wr_en_i   (wr_pen),
    .wdata_i   (reg_wdata_i[N_PERIPH-1:0]),
    .evt_i     (periph_evt_i),
    .flag_o    (pflag),
    .en_o      (pen)
  );

  irq_req_logic #(.NC(N_CORE), .NP(N_PERIPH)) u_req (
    .glb_en_i    (main_q[MAIN_GLB]),
    .grp_en_i    (main_q[MAIN_GRP]),
    .core_flag_i (main_q[N_CORE-1:0]),
    .core_en_i   (main_q[CORE_EN_LSB +: N_CORE]),
    .per_flag_i  (pflag),
    .per_en_i    (pen),
    .req_o       (irq_req_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_MAIN:  reg_rdata_o = main_q;
      ADDR_PFLAG: reg_rdata_o = DW'(pflag);
      ADDR_PEN:   reg_rdata_o = DW'(pen);
      default:    reg_rdata_o = '0;
    endcase
  end

  assert_take_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !irq_req_o);
  assert_ack_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !irq_req_o && !wr_main) |=> main_q[MAIN_GLB] == $past(main_q[MAIN_GLB]) || $past(ret_i));
  assert_glb_gates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_q[MAIN_GLB]) |-> !irq_req_o);
endmodule

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] cevt = '0;
  logic [5:0] pevt = '0;
  logic       ack = 1'b0, ret = 1'b0;
  logic       req, push;
  logic [12:0] vec;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .core_evt_i(cevt),
    .periph_evt_i(pevt), .irq_ack_i(ack), .ret_i(ret),
    .irq_req_o(req), .push_ret_o(push), .vector_o(vec)
  );

  task automatic chk(string req_id, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req_id, got, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_core(logic [2:0] e);
    @(negedge clk); cevt = e;
    @(negedge clk); cevt = '0;
  endtask

  task automatic pulse_per(logic [5:0] e);
    @(negedge clk); pevt = e;
    @(negedge clk); pevt = '0;
  endtask

  task automatic clear_all();
    wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'h00); wr_reg(2'd2, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], d); chk("R1 reg", 16'(d), 16'h0);
    end
    chk("R1 req", 16'(req), 0); chk("R1 push", 16'(push), 0);
    chk("R1 vector", 16'(vec), 16'h0004);
  endtask

  task automatic t_flags_unmasked();
    logic [7:0] d;
    pulse_core(3'b111);
    rd_reg(2'd0, d); chk("R2 core flags", 16'(d), 16'h07);
    chk("R6 no req", 16'(req), 0);
    pulse_per(6'b101010);
    rd_reg(2'd1, d); chk("R2 periph flags", 16'(d), 16'h2A);
    rd_reg(2'd3, d); chk("R3 addr3", 16'(d), 16'h0);
    wr_reg(2'd0, 8'h80);
    chk("R6 glb only", 16'(req), 0);
    clear_all();
    rd_reg(2'd1, d); chk("R9 sw clear", 16'(d), 16'h0);
  endtask

  task automatic t_core_req();
    wr_reg(2'd0, 8'h90);             // glb + timer-0 enable
    pulse_core(3'b100);              // external flag, not enabled
    chk("R4 masked", 16'(req), 0);
    wr_reg(2'd0, 8'hA4);             // glb + ext enable, keep ext flag
    chk("R4 enabled", 16'(req), 1);
    wr_reg(2'd0, 8'hA0);
    chk("R9 cleared", 16'(req), 0);
    @(negedge clk); cevt = 3'b100; #1;
    chk("R11 before edge", 16'(req), 0);
    @(negedge clk); cevt = '0;
    chk("R11 after edge", 16'(req), 1);
    wr_reg(2'd0, 8'h24);
    chk("R6 glb off", 16'(req), 0);
    clear_all();
  endtask

  task automatic t_periph_group();
    wr_reg(2'd2, 8'h04);
    wr_reg(2'd0, 8'h80);
    pulse_per(6'b000100);
    chk("R5 group off", 16'(req), 0);
    wr_reg(2'd0, 8'hC0);
    chk("R5 group on", 16'(req), 1);
    wr_reg(2'd2, 8'h00);
    chk("R5 enable off", 16'(req), 0);
    clear_all();
  endtask

  task automatic t_take_return();
    logic [7:0] d;
    wr_reg(2'd0, 8'hA4);
    chk("R7 pending", 16'(req), 1);
    @(negedge clk); ack = 1'b1; #1;
    chk("R7 push", 16'(push), 1);
    chk("R7 vector", 16'(vec), 16'h0004);
    @(negedge clk); ack = 1'b0; #1;
    chk("R7 push drop", 16'(push), 0);
    chk("R7 req drop", 16'(req), 0);
    rd_reg(2'd0, d); chk("R7 glb clear, R9 flag kept", 16'(d), 16'h24);
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
    rd_reg(2'd0, d); chk("R8 glb set", 16'(d), 16'hA4);
    chk("R9 retrigger", 16'(req), 1);
    // accept and return together: accept wins
    @(negedge clk); ack = 1'b1; ret = 1'b1;
    @(negedge clk); ack = 1'b0; ret = 1'b0;
    rd_reg(2'd0, d); chk("R7 over ret", 16'(d), 16'h24);
    clear_all();
  endtask

  task automatic t_ack_idle();
    logic [7:0] d;
    wr_reg(2'd0, 8'h80);
    @(negedge clk); ack = 1'b1; #1;
    chk("R12 no push", 16'(push), 0);
    @(negedge clk); ack = 1'b0;
    rd_reg(2'd0, d); chk("R12 glb kept", 16'(d), 16'h80);
    clear_all();
  endtask

  task automatic t_collision();
    logic [7:0] d;
    pulse_per(6'b000110);
    @(negedge clk); addr = 2'd1; wdata = 8'h00; wr = 1'b1; pevt = 6'b000001;
    @(negedge clk); wr = 1'b0; pevt = '0;
    rd_reg(2'd1, d); chk("R10 periph", 16'(d), 16'h01);
    @(negedge clk); addr = 2'd0; wdata = 8'h00; wr = 1'b1; cevt = 3'b010;
    @(negedge clk); wr = 1'b0; cevt = '0;
    rd_reg(2'd0, d); chk("R10 core", 16'(d), 16'h02);
    clear_all();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flags_unmasked();
    t_core_req();
    t_periph_group();
    t_take_return();
    t_ack_idle();
    t_collision();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule